// File: doc/BRIEF.md
# Input-Queued Crossbar Maximal-Matching Scheduler

This block decides, once per slot, which inputs of an input-queued crossbar connect to which outputs. It holds one backlog counter per (input, output) pair. A counter goes up when the arrival strobe names that pair, and it goes down when the pair is served. Because every input keeps a separate backlog toward each output, any output with waiting traffic at an input is a candidate. An input is never held back by the destination of its oldest packet.

A pulse on the slot tick opens a scheduling window of `N_PORTS` cycles. In each cycle the window visits one input. It starts at a rotating pointer and takes the inputs in ascending order, modulo the port count. The visited input claims one output that is still free and for which it has backlog. In first-fit mode the claimed output is the lowest-numbered such output. In weighted mode it is the one with the largest backlog. At the end of the window the block publishes one select per output, telling the crossbar which input drives that output, together with a valid bit. In the same cycle the block takes one packet off every served counter. The rotating pointer then moves on by one input.

The greedy pass visits every input once, and an output never becomes free again within a window. The result is therefore a maximal matching over the backlog present when the window opened. Packet storage and the data path are outside this block.

Top module: `xbar_sched`

## Requirements
- R1: An arrival with `arr_valid` high adds one to the counter of pair (`arr_in`, `arr_out`). A counter already at 2^CNT_W-1 stays there.
- R2: If an arrival and a service hit the same pair in the same cycle, that pair's counter is left unchanged.
- R3: A `slot_tick` sampled while no window is open starts a window. The outputs take the new schedule on the clock edge `N_PORTS` cycles after the edge that sampled the tick. A `slot_tick` that arrives while a window is open is ignored.
- R4: No input is granted to more than one output. Every granted pair had a nonzero counter when it was committed. Each granted counter drops by one at the commit.
- R5: The result is maximal. After a commit, no pair that had a nonzero counter when the window opened connects an input with no grant to an output whose valid bit is low.
- R6: Inputs are visited starting at the rotating pointer, which is 0 after reset and advances by one at every commit. In first-fit mode (`weighted_mode` = 0), a visited input takes the lowest-numbered output that is still free and for which it has a nonzero counter.
- R7: In weighted mode (`weighted_mode` = 1), a visited input takes the free output with the largest counter. On equal counts the lower-numbered output wins.
- R8: After reset all valid bits and selects are 0. Outputs hold their values at all times except at a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | Arrival strobe for one packet |
| arr_in | input | IDX_W | Input index of the arriving packet |
| arr_out | input | IDX_W | Output index of the arriving packet |
| slot_tick | input | 1 | Starts a scheduling window when no window is open |
| weighted_mode | input | 1 | 0 selects first-fit, 1 selects the largest backlog |
| sel_valid | output | N_PORTS | Bit o set: output o is connected this slot |
| sel_in | output | N_PORTS*IDX_W | Field o (bits o*IDX_W upward) holds the input index that drives output o |

## Verification
The bench builds the block with its default values: four ports and four-bit counters. With these values, pushing twenty packets onto one pair reaches the saturation limit of fifteen. Four consecutive slots take the rotating pointer through every starting input. A four-by-four matrix is also small enough that random traffic often produces contended outputs, ties between equal counts, and arrivals that land during an open window. These cases exercise the maximality check and the weighted tie-break.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } sched_phase_e;

    typedef enum logic {
        PICK_FIRST    = 1'b0,
        PICK_HEAVIEST = 1'b1
    } pick_mode_e;
endpackage

// File: rtl/backlog_matrix.sv
module backlog_matrix #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS),
    localparam int CELLS  = N_PORTS * N_PORTS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arr_valid,
    input  logic [IDX_W-1:0]         arr_in,
    input  logic [IDX_W-1:0]         arr_out,
    input  logic [CELLS-1:0]         dec_mask,
    output logic [CELLS*CNT_W-1:0]   counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        logic [CNT_W-1:0] cnt_d, cnt_q;
        logic             hit;

        assign hit = arr_valid
                   && (arr_in  == IDX_W'(c / N_PORTS))
                   && (arr_out == IDX_W'(c % N_PORTS));

        always_comb begin
            cnt_d = cnt_q;
            if (hit && !dec_mask[c]) begin
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            end else if (dec_mask[c] && !hit) begin
                if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign counts[c*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/pick_output.sv
module pick_output #(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS*CNT_W-1:0] row,
    input  logic [N_PORTS-1:0]       free,
    input  logic                     heaviest,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);
    logic [CNT_W-1:0] best;
    logic [CNT_W-1:0] cur;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        cur   = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            cur = row[j*CNT_W +: CNT_W];
            if (cur != '0 && free[j]) begin
                if (!found || (heaviest && cur > best)) begin
                    found = 1'b1;
                    idx   = IDX_W'(j);
                    best  = cur;
                end
            end
        end
    end
endmodule

// File: rtl/xbar_sched.sv
module xbar_sched
    import xbar_sched_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PORTS),
    localparam int CELLS  = N_PORTS * N_PORTS,
    localparam int ROW_W  = N_PORTS * CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arr_valid,
    input  logic [IDX_W-1:0]           arr_in,
    input  logic [IDX_W-1:0]           arr_out,
    input  logic                       slot_tick,
    input  logic                       weighted_mode,
    output logic [N_PORTS-1:0]         sel_valid,
    output logic [N_PORTS*IDX_W-1:0]   sel_in
);
    typedef struct packed {
        sched_phase_e                   ph;
        logic [IDX_W-1:0]               step;
        logic [IDX_W-1:0]               base;
        logic [IDX_W-1:0]               rr;
        logic [N_PORTS-1:0]             out_taken;
        logic [N_PORTS-1:0][IDX_W-1:0]  grant_in;
        logic [N_PORTS-1:0]             sel_v;
        logic [N_PORTS-1:0][IDX_W-1:0]  sel_i;
    } sched_st_t;

    sched_st_t                st_d, st_q;
    logic [CELLS*CNT_W-1:0]   counts;
    logic [CELLS-1:0]         dec_mask;
    logic [IDX_W-1:0]         cur_in;
    logic [ROW_W-1:0]         cur_row;
    logic                     pick_found;
    logic [IDX_W-1:0]         pick_idx;
    logic                     commit;
    logic                     scan_busy;
    logic                     scan_last;
    pick_mode_e               mode;

    assign mode      = pick_mode_e'(weighted_mode);
    assign cur_in    = st_q.base + st_q.step;
    assign cur_row   = counts[ROW_W*int'(cur_in) +: ROW_W];
    assign scan_busy = (st_q.ph == PH_SCAN);
    assign scan_last = (st_q.step == IDX_W'(N_PORTS - 1));

    backlog_matrix #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_valid (arr_valid),
        .arr_in    (arr_in),
        .arr_out   (arr_out),
        .dec_mask  (dec_mask),
        .counts    (counts)
    );

    pick_output #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_pick (
        .row      (cur_row),
        .free     (~st_q.out_taken),
        .heaviest (mode == PICK_HEAVIEST),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    always_comb begin
        st_d     = st_q;
        commit   = 1'b0;
        dec_mask = '0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (slot_tick) begin
                    st_d.ph        = PH_SCAN;
                    st_d.step      = '0;
                    st_d.base      = st_q.rr;
                    st_d.out_taken = '0;
                end
            end
            PH_SCAN: begin
                if (pick_found) begin
                    st_d.out_taken[pick_idx] = 1'b1;
                    st_d.grant_in[pick_idx]  = cur_in;
                end
                if (scan_last) begin
                    commit     = 1'b1;
                    st_d.ph    = PH_IDLE;
                    st_d.sel_v = st_d.out_taken;
                    st_d.sel_i = st_d.grant_in;
                    st_d.rr    = st_q.rr + 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        if (commit) begin
            for (int o = 0; o < N_PORTS; o++) begin
                if (st_d.out_taken[o])
                    dec_mask[int'(st_d.grant_in[o])*N_PORTS + o] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_valid = st_q.sel_v;
    assign sel_in    = st_q.sel_i;
endmodule

// File: rtl/xbar_sched_chk.sv
module xbar_sched_chk #(
    parameter int N_PORTS = 4,
    parameter int IDX_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      slot_tick,
    input logic                      busy,
    input logic                      last_step,
    input logic [N_PORTS-1:0]        sel_valid,
    input logic [N_PORTS*IDX_W-1:0]  sel_in
);
    logic dup_input;

    always_comb begin
        dup_input = 1'b0;
        for (int a = 0; a < N_PORTS; a++) begin
            for (int b = a + 1; b < N_PORTS; b++) begin
                if (sel_valid[a] && sel_valid[b]
                    && sel_in[a*IDX_W +: IDX_W] == sel_in[b*IDX_W +: IDX_W])
                    dup_input = 1'b1;
            end
        end
    end

    assert_input_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_input);

    assert_window_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(slot_tick));

    assert_window_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && last_step |=> !busy);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sel_valid) && $stable(sel_in));
endmodule

bind xbar_sched xbar_sched_chk #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .busy      (scan_busy),
    .last_step (scan_last),
    .sel_valid (sel_valid),
    .sel_in    (sel_in)
);

// File: tb/xbar_sched_bench.sv
`timescale 1ns/1ps
module xbar_sched_bench;
    localparam int N     = 4;
    localparam int IW    = 2;
    localparam int CMAXV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arr_valid = 1'b0;
    logic [IW-1:0] arr_in = '0;
    logic [IW-1:0] arr_out = '0;
    logic          slot_tick = 1'b0;
    logic          weighted_mode = 1'b0;
    logic [N-1:0]    sel_valid;
    logic [N*IW-1:0] sel_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit chk_en   = 1'b0;

    always #4 clk = ~clk;

    xbar_sched #(.N_PORTS(N), .CNT_W(4)) u_xbar_sched (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_in(arr_in),
        .arr_out(arr_out), .slot_tick(slot_tick), .weighted_mode(weighted_mode),
        .sel_valid(sel_valid), .sel_in(sel_in)
    );

    // ---------------- behavioural reference ----------------
    int m_cnt [N][N];
    int m_snap[N][N];
    int m_pre [N][N];
    bit m_dec [N][N];
    bit m_used[N];
    bit m_gv  [N];
    int m_gi  [N];
    bit m_sv  [N];
    int m_si  [N];
    bit m_busy;
    int m_step, m_base, m_rr;
    bit m_commit;

    function automatic int m_pick(int i, bit heavy);
        int best = 0;
        int pj = -1;
        for (int j = 0; j < N; j++) begin
            if (m_cnt[i][j] > 0 && !m_used[j]) begin
                if (pj < 0 || (heavy && m_cnt[i][j] > best)) begin
                    pj = j;
                    best = m_cnt[i][j];
                end
            end
        end
        return pj;
    endfunction

    always @(posedge clk) begin
        m_commit = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) m_cnt[i][j] = 0;
                m_sv[i] = 0; m_si[i] = 0; m_gv[i] = 0; m_gi[i] = 0; m_used[i] = 0;
            end
            m_busy = 0; m_step = 0; m_base = 0; m_rr = 0;
        end else begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) m_dec[i][j] = 0;
            if (m_busy) begin
                int ci;
                int pj;
                ci = (m_base + m_step) % N;
                pj = m_pick(ci, weighted_mode);
                if (pj >= 0) begin
                    m_used[pj] = 1; m_gv[pj] = 1; m_gi[pj] = ci;
                end
                if (m_step == N - 1) begin
                    m_pre = m_cnt;
                    for (int o = 0; o < N; o++) begin
                        m_sv[o] = m_gv[o];
                        m_si[o] = m_gi[o];
                        if (m_gv[o]) m_dec[m_gi[o]][o] = 1;
                    end
                    m_rr = (m_rr + 1) % N;
                    m_busy = 0;
                    m_commit = 1;
                end else begin
                    m_step++;
                end
            end else if (slot_tick) begin
                m_busy = 1; m_step = 0; m_base = m_rr;
                for (int o = 0; o < N; o++) begin m_used[o] = 0; m_gv[o] = 0; end
                m_snap = m_cnt;
            end
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    bit a;
                    a = arr_valid && (int'(arr_in) == i) && (int'(arr_out) == j);
                    if (a && !m_dec[i][j]) begin
                        if (m_cnt[i][j] < CMAXV) m_cnt[i][j]++;
                    end else if (m_dec[i][j] && !a) begin
                        m_cnt[i][j]--;
                    end
                end
            end
        end
    end

    function automatic int dut_in(int o);
        return int'(sel_in[o*IW +: IW]);
    endfunction

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (chk_en && rst_n) begin
            bit bad;
            bad = 0;
            for (int o = 0; o < N; o++) begin
                if (sel_valid[o] != m_sv[o]) bad = 1;
                if (sel_valid[o] && dut_in(o) != m_si[o]) bad = 1;
            end
            n_checks++;
            if (bad) begin
                n_fail++;
                $display("FAIL R6/R7 per-cycle: sel_valid=%b sel_in=%h expected valid=%b%b%b%b in=%0d%0d%0d%0d",
                    sel_valid, sel_in, m_sv[3], m_sv[2], m_sv[1], m_sv[0],
                    m_si[3], m_si[2], m_si[1], m_si[0]);
            end
            if (m_commit) begin
                bit in_used[N];
                bit r4_bad;
                bit r5_bad;
                r4_bad = 0; r5_bad = 0;
                for (int i = 0; i < N; i++) in_used[i] = 0;
                for (int o = 0; o < N; o++) begin
                    if (sel_valid[o]) begin
                        if (in_used[dut_in(o)]) r4_bad = 1;
                        in_used[dut_in(o)] = 1;
                        if (m_pre[dut_in(o)][o] == 0) r4_bad = 1;
                    end
                end
                n_checks++;
                if (r4_bad) begin
                    n_fail++;
                    $display("FAIL R4 matching: sel_valid=%b sel_in=%h expected distinct inputs with backlog",
                        sel_valid, sel_in);
                end
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++)
                        if (!in_used[i] && !sel_valid[j] && m_snap[i][j] > 0) r5_bad = 1;
                n_checks++;
                if (r5_bad) begin
                    n_fail++;
                    $display("FAIL R5 maximality: sel_valid=%b sel_in=%h expected no free backlog pair left",
                        sel_valid, sel_in);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        chk_en = 0;
        @(negedge clk);
        arr_valid = 0; slot_tick = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        chk_en = 1;
    endtask

    task automatic push(int i, int j);
        @(negedge clk);
        slot_tick = 0;
        arr_valid = 1; arr_in = IW'(i); arr_out = IW'(j);
    endtask

    task automatic run_slot();
        @(negedge clk);
        arr_valid = 0; slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        repeat (N) @(negedge clk);
    endtask

    task automatic traffic_slot();
        @(negedge clk);
        slot_tick = 1;
        weighted_mode = 1'($urandom_range(0, 1));
        arr_valid = 1'($urandom_range(0, 1));
        arr_in = IW'($urandom_range(0, N-1)); arr_out = IW'($urandom_range(0, N-1));
        repeat (N) begin
            @(negedge clk);
            slot_tick = 0;
            arr_valid = 1'($urandom_range(0, 1));
            arr_in = IW'($urandom_range(0, N-1)); arr_out = IW'($urandom_range(0, N-1));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt;
        do_reset();
        // R8: reset state
        @(negedge clk);
        check(sel_valid == 0, "R8 reset valid", int'(sel_valid), 0);
        check(sel_in == 0, "R8 reset select", int'(sel_in), 0);

        // R6: first-fit picks lowest free output with backlog
        push(0, 3); push(0, 1);
        weighted_mode = 0;
        run_slot();
        check(sel_valid == 4'b0010, "R6 first-fit valid", int'(sel_valid), 2);
        check(dut_in(1) == 0, "R6 first-fit input", dut_in(1), 0);

        // R7: weighted picks largest count, ties to lower index
        do_reset();
        push(2, 0);
        repeat (3) push(2, 1);
        repeat (3) push(2, 3);
        @(negedge clk); arr_valid = 0; weighted_mode = 1;
        run_slot();
        check(sel_valid == 4'b0010, "R7 tie lower index", int'(sel_valid), 2);
        run_slot();
        check(sel_valid == 4'b1000, "R7 heaviest", int'(sel_valid), 8);
        check(dut_in(3) == 2, "R7 heaviest input", dut_in(3), 2);
        weighted_mode = 0;

        // R6: rotating start pointer
        do_reset();
        push(0, 0); push(0, 0); push(1, 0); push(1, 0);
        run_slot();
        check(sel_valid[0] && dut_in(0) == 0, "R6 pointer slot0", dut_in(0), 0);
        run_slot();
        check(sel_valid[0] && dut_in(0) == 1, "R6 pointer slot1", dut_in(0), 1);

        // R1: saturation at 15
        do_reset();
        repeat (20) push(3, 2);
        cnt = 0;
        repeat (20) begin
            run_slot();
            if (sel_valid[2] && dut_in(2) == 3) cnt++;
        end
        check(cnt == 15, "R1 saturation grants", cnt, 15);

        // R2: arrival coinciding with service
        do_reset();
        push(1, 2);
        @(negedge clk); arr_valid = 0; slot_tick = 1;
        @(negedge clk); slot_tick = 0;
        repeat (2) @(negedge clk);
        @(negedge clk); arr_valid = 1; arr_in = 2'd1; arr_out = 2'd2;
        @(negedge clk); arr_valid = 0;
        cnt = (sel_valid[2] && dut_in(2) == 1) ? 1 : 0;
        repeat (2) begin
            run_slot();
            if (sel_valid[2] && dut_in(2) == 1) cnt++;
        end
        check(cnt == 2, "R2 same-cycle arrival and service", cnt, 2);
        check(sel_valid == 0, "R4 backlog drained", int'(sel_valid), 0);

        // R3: window timing and ignored tick
        do_reset();
        push(2, 1);
        @(negedge clk); arr_valid = 0; slot_tick = 1;
        @(negedge clk); slot_tick = 0;
        @(negedge clk); slot_tick = 1;
        @(negedge clk); slot_tick = 0;
        check(sel_valid == 0, "R3 not yet committed n3", int'(sel_valid), 0);
        @(negedge clk);
        check(sel_valid == 0, "R3 not yet committed n4", int'(sel_valid), 0);
        @(negedge clk);
        check(sel_valid == 4'b0010, "R3 commit after N cycles", int'(sel_valid), 2);
        repeat (8) @(negedge clk);
        check(sel_valid == 4'b0010, "R3 tick in window ignored", int'(sel_valid), 2);

        // R4/R5: random traffic, compared every cycle
        do_reset();
        repeat (400) traffic_slot();
        @(negedge clk); arr_valid = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule